// File: doc/BRIEF.md
# Local Interrupt Acceptance Controller

This block is the message-acceptance front end of a per-processor interrupt controller. Each cycle it may receive one inter-processor interrupt message. The message carries a delivery mode, an 8-bit vector, a trigger-mode bit, a level bit, a destination mode, an 8-bit destination, and a flag that marks it as issued from the command register. The block decides whether the message is addressed to this processor and whether the current enable state allows it. An accepted fixed-mode message is recorded in a 256-entry request register, and its effective trigger mode is recorded in a trigger-mode register. An accepted system message (SMI, NMI, INIT, start-up) is passed out as a one-cycle event.

A small local vector table holds one mask bit per local interrupt line. A rising edge on an unmasked line requests vector `LVT_BASE + index` as an edge-triggered interrupt. The block is gated by a software enable bit. Clearing that bit sets every table mask and restricts acceptance to system messages. It leaves every other register untouched. The output is the highest pending vector whose priority class (vector bits 7:4) is above the highest in-service class. An acknowledge strobe moves that vector into service, and an end-of-interrupt strobe retires the highest in-service vector.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the controller is disabled, every table mask bit is 1, nothing is pending, and no accept or event pulse is issued.
- R2: A message with destination-mode bit 0 (physical) hits when destination bits 3:0 equal the ID register or are 4'hF. With destination-mode bit 1 (logical) it hits when the bitwise AND of the destination and the logical destination register is nonzero. A message that misses is never accepted. Accept and event outputs appear in the cycle after the message.
- R3: While enabled, a hitting message with delivery code 000 (fixed) sets its vector's request bit, and the vector becomes visible on the pending output after one clock edge.
- R4: Writing 0 to the enable bit (selector 0, data bit 0) clears the enable and sets every table mask bit. The request, in-service and trigger-mode registers, the ID and the logical destination are unchanged, so the pending output stays as it was.
- R5: While disabled, only codes 010 (SMI), 100 (NMI), 101 (INIT) and 110 (start-up) can be accepted, and code 000 is dropped. Codes 001, 011 and 111 are never accepted.
- R6: An accepted NMI, or an accepted INIT other than INIT deassert, reports edge trigger even when the message asks for level. INIT deassert is code 101 with trigger bit 1 and level bit 0, and it keeps level trigger.
- R7: A message flagged as issued from the command register takes edge trigger, except INIT deassert.
- R8: The trigger-mode bit of an accepted fixed vector holds the effective trigger after any forced-edge rule. The pending-level output shows that bit for the pending vector.
- R9: A rising edge on local line i with its mask bit clear requests vector LVT_BASE+i as edge-triggered. A rise on a masked line is ignored. Setting the enable bit again leaves the masks set. Selector 3 writes the masks from data bits.
- R10: A vector is pending only when its class is above the highest in-service class. Acknowledge moves the pending vector from request to in-service, and end-of-interrupt clears the highest in-service bit.
- R11: The ID register keeps only data bits 3:0 of a selector 1 write. The logical destination register keeps all 8 bits of a selector 2 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 enable, 1 ID, 2 logical destination, 3 table masks |
| cfgData | input | 8 | Configuration write data |
| msgValid | input | 1 | Incoming message present |
| msgMode | input | 3 | Delivery mode code |
| msgVector | input | 8 | Message vector |
| msgTrigLevel | input | 1 | 1 = level trigger requested |
| msgLevel | input | 1 | Level (assert) bit |
| msgLogical | input | 1 | 1 = logical destination mode |
| msgDest | input | 8 | Destination field |
| msgFromIcr | input | 1 | Message issued from command register |
| localIrq | input | LVT_N | Local interrupt lines |
| ackReq | input | 1 | Acknowledge pending vector |
| eoiReq | input | 1 | End of interrupt |
| enabled | output | 1 | Software enable state |
| lvtMask | output | LVT_N | Table mask bits |
| msgAccept | output | 1 | Previous-cycle message accepted |
| evtValid | output | 1 | System message event |
| evtMode | output | 3 | Event delivery code |
| evtVector | output | 8 | Event vector |
| evtLevelTrig | output | 1 | Event effective trigger |
| pendValid | output | 1 | A deliverable vector exists |
| pendVector | output | 8 | Highest deliverable vector |
| pendLevel | output | 1 | Trigger-mode bit of pending vector |

## Verification
The bench targets the INIT deassert exception. A design that forces every INIT to edge, or lets command-register messages keep level, reports the wrong trigger on the event or on the pending-level output. It also targets a disable issued while vectors are pending: a design that clears the request or in-service state loses the pending vector, and one that forgets the masks still takes local edges. It checks that fixed messages are dropped while disabled and that undefined codes are refused everywhere. It checks the class comparison against in-service, where a design that compares whole vectors instead of classes delivers a same-class vector too early.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int VEC_W = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int MAX_LOCAL = 8;

  localparam logic [2:0] DM_FIXED   = 3'b000;
  localparam logic [2:0] DM_SMI     = 3'b010;
  localparam logic [2:0] DM_NMI     = 3'b100;
  localparam logic [2:0] DM_INIT    = 3'b101;
  localparam logic [2:0] DM_STARTUP = 3'b110;

  localparam logic [1:0] CFG_ENABLE = 2'd0;
  localparam logic [1:0] CFG_ID     = 2'd1;
  localparam logic [1:0] CFG_LDEST  = 2'd2;
  localparam logic [1:0] CFG_LMASK  = 2'd3;

  typedef struct packed {
    logic                 msgSet;
    logic [VEC_W-1:0]     msgVec;
    logic                 msgLevel;
    logic [MAX_LOCAL-1:0] localSet;
    logic                 ack;
    logic                 eoi;
  } dpStrobe_t;
endpackage

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int LVT_N   = 4,
  parameter int ID_W    = 4,
  parameter int LDEST_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [7:0]         cfgData,
  input  logic               msgValid,
  input  logic [2:0]         msgMode,
  input  logic [VEC_W-1:0]   msgVector,
  input  logic               msgTrigLevel,
  input  logic               msgLevel,
  input  logic               msgLogical,
  input  logic [LDEST_W-1:0] msgDest,
  input  logic               msgFromIcr,
  input  logic [LVT_N-1:0]   localIrq,
  input  logic               ackReq,
  input  logic               eoiReq,
  output dpStrobe_t          strobe,
  output logic               enabled,
  output logic [LVT_N-1:0]   lvtMask,
  output logic               msgAccept,
  output logic               evtValid,
  output logic [2:0]         evtMode,
  output logic [VEC_W-1:0]   evtVector,
  output logic               evtLevelTrig
);
  logic [ID_W-1:0]    idReg;
  logic [LDEST_W-1:0] ldestReg;
  logic [LVT_N-1:0]   localPrev;

  logic initDeassert, forceEdge, effLevel;
  logic modeKnown, modeSystem, destHit, accept;
  logic [LVT_N-1:0] localRise;

  always_comb begin
    initDeassert = (msgMode == DM_INIT) && msgTrigLevel && !msgLevel;
    forceEdge    = !initDeassert &&
                   ((msgMode == DM_NMI) || (msgMode == DM_INIT) || msgFromIcr);
    effLevel     = msgTrigLevel && !forceEdge;
    modeSystem   = (msgMode == DM_SMI) || (msgMode == DM_NMI) ||
                   (msgMode == DM_INIT) || (msgMode == DM_STARTUP);
    modeKnown    = modeSystem || (msgMode == DM_FIXED);
    if (msgLogical) destHit = |(msgDest & ldestReg);
    else            destHit = (msgDest[ID_W-1:0] == idReg) || (&msgDest[ID_W-1:0]);
    accept       = msgValid && destHit && (enabled ? modeKnown : modeSystem);
    localRise    = localIrq & ~localPrev & ~lvtMask;
  end

  always_comb begin
    strobe          = '0;
    strobe.msgSet   = accept && (msgMode == DM_FIXED);
    strobe.msgVec   = msgVector;
    strobe.msgLevel = effLevel;
    strobe.localSet = MAX_LOCAL'(localRise);
    strobe.ack      = ackReq;
    strobe.eoi      = eoiReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled   <= 1'b0;
      lvtMask   <= '1;
      idReg     <= '0;
      ldestReg  <= '0;
      localPrev <= '0;
    end else begin
      localPrev <= localIrq;
      if (cfgWe) begin
        unique case (cfgSel)
          CFG_ENABLE: begin
            enabled <= cfgData[0];
            if (!cfgData[0]) lvtMask <= '1;
          end
          CFG_ID:    idReg    <= cfgData[ID_W-1:0];
          CFG_LDEST: ldestReg <= cfgData[LDEST_W-1:0];
          default:   lvtMask  <= cfgData[LVT_N-1:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgAccept    <= 1'b0;
      evtValid     <= 1'b0;
      evtMode      <= '0;
      evtVector    <= '0;
      evtLevelTrig <= 1'b0;
    end else begin
      msgAccept <= accept;
      evtValid  <= accept && (msgMode != DM_FIXED);
      if (accept && (msgMode != DM_FIXED)) begin
        evtMode      <= msgMode;
        evtVector    <= msgVector;
        evtLevelTrig <= effLevel;
      end
    end
  end
endmodule

// File: rtl/irq_accept_dp.sv
module irq_accept_dp
  import irq_accept_pkg::*;
#(
  parameter int LVT_N    = 4,
  parameter int LVT_BASE = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic             pendValid,
  output logic [VEC_W-1:0] pendVector,
  output logic             pendLevel
);
  localparam int CLS_LSB = VEC_W - 4;

  logic [NUM_VEC-1:0] irrQ, isrQ, tmrQ, irrN, isrN, tmrN;
  logic [VEC_W:0]     irrTop, isrTop;

  function automatic logic [VEC_W:0] topBit(input logic [NUM_VEC-1:0] v);
    logic [VEC_W:0] r;
    r = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (v[i]) r = {1'b1, VEC_W'(i)};
    return r;
  endfunction

  always_comb begin
    irrTop     = topBit(irrQ);
    isrTop     = topBit(isrQ);
    pendVector = irrTop[VEC_W-1:0];
    pendValid  = irrTop[VEC_W] &&
                 (!isrTop[VEC_W] ||
                  (irrTop[VEC_W-1:CLS_LSB] > isrTop[VEC_W-1:CLS_LSB]));
    pendLevel  = tmrQ[pendVector];
  end

  always_comb begin
    irrN = irrQ;
    isrN = isrQ;
    tmrN = tmrQ;
    if (strobe.ack && pendValid) begin
      irrN[pendVector] = 1'b0;
      isrN[pendVector] = 1'b1;
    end
    if (strobe.eoi && isrTop[VEC_W]) isrN[isrTop[VEC_W-1:0]] = 1'b0;
    if (strobe.msgSet) begin
      irrN[strobe.msgVec] = 1'b1;
      tmrN[strobe.msgVec] = strobe.msgLevel;
    end
    for (int i = 0; i < LVT_N; i++) begin
      if (strobe.localSet[i]) begin
        irrN[VEC_W'(LVT_BASE + i)] = 1'b1;
        tmrN[VEC_W'(LVT_BASE + i)] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ <= '0;
      isrQ <= '0;
      tmrQ <= '0;
    end else begin
      irrQ <= irrN;
      isrQ <= isrN;
      tmrQ <= tmrN;
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int LVT_N    = 4,
  parameter int LVT_BASE = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [7:0]       cfgData,
  input  logic             msgValid,
  input  logic [2:0]       msgMode,
  input  logic [7:0]       msgVector,
  input  logic             msgTrigLevel,
  input  logic             msgLevel,
  input  logic             msgLogical,
  input  logic [7:0]       msgDest,
  input  logic             msgFromIcr,
  input  logic [LVT_N-1:0] localIrq,
  input  logic             ackReq,
  input  logic             eoiReq,
  output logic             enabled,
  output logic [LVT_N-1:0] lvtMask,
  output logic             msgAccept,
  output logic             evtValid,
  output logic [2:0]       evtMode,
  output logic [7:0]       evtVector,
  output logic             evtLevelTrig,
  output logic             pendValid,
  output logic [7:0]       pendVector,
  output logic             pendLevel
);
  dpStrobe_t strobe;

  irq_accept_ctrl #(.LVT_N(LVT_N), .ID_W(4), .LDEST_W(8)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .msgValid(msgValid), .msgMode(msgMode), .msgVector(msgVector),
    .msgTrigLevel(msgTrigLevel), .msgLevel(msgLevel), .msgLogical(msgLogical),
    .msgDest(msgDest), .msgFromIcr(msgFromIcr), .localIrq(localIrq),
    .ackReq(ackReq), .eoiReq(eoiReq), .strobe(strobe), .enabled(enabled),
    .lvtMask(lvtMask), .msgAccept(msgAccept), .evtValid(evtValid),
    .evtMode(evtMode), .evtVector(evtVector), .evtLevelTrig(evtLevelTrig)
  );

  irq_accept_dp #(.LVT_N(LVT_N), .LVT_BASE(LVT_BASE)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pendValid(pendValid), .pendVector(pendVector), .pendLevel(pendLevel)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int LVT_N = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [1:0]       cfgSel,
  input logic [7:0]       cfgData,
  input logic             msgValid,
  input logic [2:0]       msgMode,
  input logic [LVT_N-1:0] localIrq,
  input logic             ackReq,
  input logic             eoiReq,
  input logic             enabled,
  input logic [LVT_N-1:0] lvtMask,
  input logic             msgAccept,
  input logic             evtValid,
  input logic [2:0]       evtMode,
  input logic             evtLevelTrig,
  input logic             pendValid,
  input logic [7:0]       pendVector
);
  // R4
  disable_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel == 2'd0 && !cfgData[0]) |=> (&lvtMask && !enabled));

  // R4
  disable_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel == 2'd0 && !cfgData[0] && !msgValid && !ackReq && !eoiReq && &lvtMask)
    |=> ($stable(pendValid) && $stable(pendVector)));

  // R5
  disabled_fixed_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !enabled && msgMode == 3'b000) |=> !msgAccept);

  // R5
  unknown_mode_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && (msgMode == 3'b001 || msgMode == 3'b011 || msgMode == 3'b111)) |=> !msgAccept);

  // R6
  nmi_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtMode == 3'b100) |-> !evtLevelTrig);

  // R10
  ack_retires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && pendValid && !msgValid && !eoiReq && localIrq == '0)
    |=> !(pendValid && pendVector == $past(pendVector)));
endmodule

bind irq_accept_unit irq_accept_chk #(.LVT_N(LVT_N)) i_chk (.*);

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LVT_N = 4;
  localparam int LVT_BASE = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0; logic [1:0] cfgSel = 0; logic [7:0] cfgData = 0;
  logic msgValid = 0; logic [2:0] msgMode = 0; logic [7:0] msgVector = 0;
  logic msgTrigLevel = 0, msgLevel = 0, msgLogical = 0, msgFromIcr = 0;
  logic [7:0] msgDest = 0; logic [LVT_N-1:0] localIrq = 0;
  logic ackReq = 0, eoiReq = 0;
  logic enabled, msgAccept, evtValid, evtLevelTrig, pendValid, pendLevel;
  logic [LVT_N-1:0] lvtMask; logic [2:0] evtMode; logic [7:0] evtVector, pendVector;

  int checks = 0, failures = 0;

  logic [255:0] mIrr, mIsr, mTmr;
  logic mEn; logic [LVT_N-1:0] mMask, mPrev; logic [3:0] mId; logic [7:0] mLdr;
  logic eAcc, eEvt, eEvtLvl; logic [2:0] eEvtMode; logic [7:0] eEvtVec;

  irq_accept_unit #(.LVT_N(LVT_N), .LVT_BASE(LVT_BASE)) i_irq_accept_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int top(input logic [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic mPendValid();
    int a = top(mIrr), b = top(mIsr);
    return (a >= 0) && (b < 0 || (a >> 4) > (b >> 4));
  endfunction

  task automatic idle();
    cfgWe = 0; msgValid = 0; ackReq = 0; eoiReq = 0;
  endtask

  // model of one clock edge, then compare outputs after it
  task automatic stepCycle(input string tag);
    logic hit, sys, known, initDe, lvl, pv; logic [LVT_N-1:0] rise; int pvec, it;
    initDe = (msgMode == 3'b101) && msgTrigLevel && !msgLevel;
    lvl = msgTrigLevel && (initDe || !(msgMode == 3'b100 || msgMode == 3'b101 || msgFromIcr));
    hit = msgLogical ? ((msgDest & mLdr) != 0) : (msgDest[3:0] == mId || msgDest[3:0] == 4'hF);
    sys = msgMode inside {3'b010, 3'b100, 3'b101, 3'b110};
    known = sys || msgMode == 3'b000;
    eAcc = msgValid && hit && (mEn ? known : sys);
    eEvt = eAcc && msgMode != 3'b000;
    if (eEvt) begin eEvtMode = msgMode; eEvtVec = msgVector; eEvtLvl = lvl; end
    rise = localIrq & ~mPrev & ~mMask;
    pv = mPendValid(); pvec = top(mIrr); it = top(mIsr);
    if (ackReq && pv) begin mIrr[pvec] = 0; mIsr[pvec] = 1; end
    if (eoiReq && it >= 0) mIsr[it] = 0;
    if (eAcc && msgMode == 3'b000) begin mIrr[msgVector] = 1; mTmr[msgVector] = lvl; end
    for (int i = 0; i < LVT_N; i++)
      if (rise[i]) begin mIrr[LVT_BASE+i] = 1; mTmr[LVT_BASE+i] = 0; end
    mPrev = localIrq;
    if (cfgWe) case (cfgSel)
      2'd0: begin mEn = cfgData[0]; if (!cfgData[0]) mMask = '1; end
      2'd1: mId = cfgData[3:0];
      2'd2: mLdr = cfgData;
      default: mMask = cfgData[LVT_N-1:0];
    endcase
    @(posedge clk); #1;
    check(msgAccept == eAcc, "R2", {tag, " accept"}, msgAccept, eAcc);
    check(evtValid == eEvt, "R5", {tag, " event"}, evtValid, eEvt);
    if (eEvt) begin
      check(evtMode == eEvtMode && evtVector == eEvtVec, "R6", {tag, " event fields"},
            {evtMode, evtVector}, {eEvtMode, eEvtVec});
      check(evtLevelTrig == eEvtLvl, "R7", {tag, " event trigger"}, evtLevelTrig, eEvtLvl);
    end
    check(enabled == mEn, "R4", {tag, " enable"}, enabled, mEn);
    check(lvtMask == mMask, "R9", {tag, " masks"}, lvtMask, mMask);
    check(pendValid == mPendValid(), "R10", {tag, " pend valid"}, pendValid, mPendValid());
    if (mPendValid()) begin
      check(pendVector == 8'(top(mIrr)), "R3", {tag, " pend vector"}, pendVector, top(mIrr));
      check(pendLevel == mTmr[top(mIrr)], "R8", {tag, " pend level"}, pendLevel, mTmr[top(mIrr)]);
    end
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] d, input string tag);
    idle(); cfgWe = 1; cfgSel = s; cfgData = d; stepCycle(tag); idle();
  endtask

  task automatic send(input logic [2:0] m, input logic [7:0] v, input logic t, input logic l,
                      input logic lg, input logic [7:0] d, input logic icr, input string tag);
    idle(); msgValid = 1; msgMode = m; msgVector = v; msgTrigLevel = t; msgLevel = l;
    msgLogical = lg; msgDest = d; msgFromIcr = icr; stepCycle(tag); idle();
  endtask

  initial begin
    mIrr = '0; mIsr = '0; mTmr = '0; mEn = 0; mMask = '1; mPrev = '0; mId = 0; mLdr = 0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!enabled && lvtMask == '1 && !pendValid && !msgAccept && !evtValid, "R1",
          "reset state", {enabled, lvtMask, pendValid, msgAccept, evtValid}, {1'b0, 4'hF, 3'b0});

    cfg(2'd0, 8'h01, "R3 enable");
    cfg(2'd1, 8'hA5, "R11 id");
    cfg(2'd2, 8'h0C, "R11 ldest");
    cfg(2'd3, 8'h00, "R9 unmask");
    send(3'b000, 8'h50, 1, 1, 0, 8'h05, 0, "R11 id low bits");
    check(pendVector == 8'h50 && pendLevel, "R8", "level fixed recorded", {pendVector, pendLevel}, {8'h50, 1'b1});
    send(3'b000, 8'h60, 0, 1, 0, 8'h06, 0, "R2 phys miss");
    send(3'b000, 8'h70, 0, 1, 1, 8'h04, 0, "R2 logical hit");
    send(3'b000, 8'h80, 0, 1, 1, 8'h30, 0, "R2 logical miss");
    send(3'b000, 8'h90, 1, 1, 0, 8'h0F, 1, "R7 icr edge");
    check(pendVector == 8'h90 && !pendLevel, "R7", "icr fixed edge", {pendVector, pendLevel}, {8'h90, 1'b0});
    send(3'b100, 8'h02, 1, 1, 0, 8'h05, 0, "R6 nmi");
    check(evtValid && !evtLevelTrig, "R6", "nmi forced edge", evtLevelTrig, 0);
    send(3'b101, 8'h00, 1, 1, 0, 8'h05, 0, "R6 init assert");
    send(3'b101, 8'h00, 1, 0, 0, 8'h05, 1, "R6 init deassert");
    check(evtValid && evtLevelTrig, "R6", "init deassert level", evtLevelTrig, 1);
    localIrq = 4'b0010; stepCycle("R9 local rise");
    localIrq = 4'b0000;
    ackReq = 1; stepCycle("R10 ack top"); idle();
    send(3'b000, 8'h95, 0, 1, 0, 8'h05, 0, "R10 same class");
    check(!pendValid || pendVector != 8'h95, "R10", "same class blocked", pendVector, 0);
    eoiReq = 1; stepCycle("R10 eoi"); idle();
    cfg(2'd0, 8'h00, "R4 disable");
    check(pendValid && pendVector == 8'h95, "R4", "pending kept", pendVector, 8'h95);
    send(3'b000, 8'hA0, 0, 1, 0, 8'h05, 0, "R5 fixed dropped");
    send(3'b010, 8'h00, 0, 1, 0, 8'h05, 0, "R5 smi kept");
    send(3'b110, 8'h08, 0, 1, 0, 8'h05, 0, "R5 startup kept");
    send(3'b011, 8'h00, 0, 1, 0, 8'h05, 0, "R5 undefined code");
    localIrq = 4'b0001; stepCycle("R9 masked rise"); localIrq = 4'b0000;
    check(!(pendValid && pendVector == 8'(LVT_BASE)), "R9", "masked rise ignored", pendVector, 0);
    cfg(2'd0, 8'h01, "R9 reenable");
    check(lvtMask == '1, "R9", "masks stay after enable", lvtMask, 4'hF);
    send(3'b111, 8'h00, 0, 1, 0, 8'h0F, 0, "R5 undefined enabled");
    cfg(2'd3, 8'h00, "R9 unmask again");

    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 100 < 5) begin
        cfgWe = 1; cfgSel = 2'($urandom); cfgData = 8'($urandom);
        if (cfgSel == 2'd0 && ($urandom % 4) != 0) cfgData[0] = 1'b1;
        if (cfgSel == 2'd3 && ($urandom % 2) != 0) cfgData = 8'h00;
      end
      if ($urandom % 3 != 0) begin
        msgValid = 1;
        msgMode = ($urandom % 2 != 0) ? 3'b000 : 3'($urandom);
        msgVector = 8'(16 + $urandom % 240);
        msgTrigLevel = 1'($urandom); msgLevel = 1'($urandom);
        msgLogical = 1'($urandom); msgFromIcr = 1'($urandom);
        case ($urandom % 3)
          0: msgDest = {4'($urandom), mId};
          1: msgDest = {4'($urandom), 4'hF};
          default: msgDest = 8'($urandom);
        endcase
      end
      if ($urandom % 6 == 0) localIrq = LVT_N'($urandom);
      ackReq = ($urandom % 5 == 0);
      eoiReq = ($urandom % 6 == 0);
      stepCycle("rand");
    end
    idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule